// File: doc/BRIEF.md
# Chunked Buffer Error Logger

This block keeps ECC error marks for a line-based data buffer and reduces them to a first-error record, a next-error summary and one upstream report per line. The memory side fills the buffer one 8-byte ECC word at a time. Each write carries decoded correctable and uncorrectable flags, and these are merged into a mark held for the 16-byte chunk the word belongs to. A line is four chunks. Several line slots are tracked at the same time.

Errors are counted as data leaves the buffer. When a chunk is forwarded and its mark shows a fault, that chunk counts as one error. If the first-error record is empty, the error loads it. If the record is already full, the error sets the sticky next-error bit for its class. When the last chunk of a line is forwarded, a registered report goes upstream with the combined correctable and uncorrectable state of the whole line, and the marks of that line slot are cleared. Software clears the first-error record and the next-error bits with write-one-to-clear pulses.

Top module: `chunk_err_logger`

## Requirements
- R1: After reset the first-error record is invalid, both next-error bits are 0 and no upstream report is pending.
- R2: A flagged 8-byte write only marks its chunk. The first-error record does not change until that chunk is forwarded.
- R3: One chunk with both of its 8-byte words flagged counts as a single error. It loads the first-error record only, and both next-error bits stay 0.
- R4: A line with faults in two different chunks loads the first-error record from the chunk forwarded first and sets a next-error bit for the later chunk.
- R5: The first-error record loads only while it is invalid. It holds the line slot, the chunk index and a severity bit (1 = uncorrectable), and an uncorrectable flag on either word makes the chunk uncorrectable. The record stays unchanged until it is cleared.
- R6: While the first-error record is valid, each further faulty chunk sets next_ue if it is uncorrectable and next_ce otherwise. The bits are sticky.
- R7: Forwarding chunk index 3 of a line raises up_valid for exactly one cycle on the next clock. up_ce and up_ue are the OR of all chunk marks of that line. No other chunk index produces a report.
- R8: A line without marks is still reported, with up_ce = 0 and up_ue = 0.
- R9: After chunk 3 of a line is forwarded, that line slot holds no marks. Forwarding it again produces no error and a clean report.
- R10: A clr_first pulse invalidates the record and a clr_next pulse zeroes both next-error bits. If a clear and a faulty forwarded chunk fall in the same cycle, the clear takes effect first and the new error is then logged: it loads the record after clr_first, or sets its next-error bit after clr_next.
- R11: Marks are kept separately for each line slot. Faults written to one slot never appear in the report or the log of another slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | An 8-byte word is entering the buffer |
| wr_line | input | 2 | Line slot being filled |
| wr_chunk | input | 2 | Chunk index of the word within the line |
| wr_ce | input | 1 | Word had a correctable ECC error |
| wr_ue | input | 1 | Word had an uncorrectable ECC error |
| fwd_en | input | 1 | A chunk is being sent to its target |
| fwd_line | input | 2 | Line slot being forwarded |
| fwd_chunk | input | 2 | Chunk index being forwarded (3 is the last) |
| clr_first | input | 1 | Write-one-to-clear pulse for the first-error record |
| clr_next | input | 1 | Write-one-to-clear pulse for the next-error bits |
| up_valid | output | 1 | Upstream report strobe, one per line |
| up_ce | output | 1 | Line had a correctable fault |
| up_ue | output | 1 | Line had an uncorrectable fault |
| first_valid | output | 1 | First-error record holds an error |
| first_ue | output | 1 | First error was uncorrectable (0 = correctable) |
| first_line | output | 2 | Line slot of the first error |
| first_chunk | output | 2 | Chunk index of the first error |
| next_ce | output | 1 | A later correctable error occurred |
| next_ue | output | 1 | A later uncorrectable error occurred |

## Verification
A software clear and the logging of a newly forwarded faulty chunk can fall in the same cycle. The bench provokes this twice. In one case a fault is forwarded together with clr_first, and the record must hold the new chunk while the next-error bits stay 0. In the other case, with the record full, a fault is forwarded together with clr_next, and the matching next-error bit must end up set rather than cleared. Every upstream report is also compared, as it appears, against the line state that the bench predicts.

// File: rtl/ebl_pkg.sv
package ebl_pkg;

    // Error mark held per 16-byte chunk
    typedef struct packed {
        logic ue;
        logic ce;
    } mark_t;

    function automatic logic mark_any(input mark_t m);
        return m.ue | m.ce;
    endfunction

endpackage

// File: rtl/ebl_mark_store.sv
module ebl_mark_store
    import ebl_pkg::*;
#(
    parameter int NUM_LINES  = 4,
    parameter int NUM_CHUNKS = 4,
    parameter int LINE_W     = 2,
    parameter int CHUNK_W    = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [LINE_W-1:0]  wr_line,
    input  logic [CHUNK_W-1:0] wr_chunk,
    input  mark_t              wr_mark,
    input  logic               fwd_en,
    input  logic [LINE_W-1:0]  fwd_line,
    input  logic [CHUNK_W-1:0] fwd_chunk,
    output mark_t              chunk_mark,
    output mark_t              line_mark,
    output logic               line_done
);

    localparam logic [CHUNK_W-1:0] LAST_CHUNK = CHUNK_W'(NUM_CHUNKS - 1);

    typedef struct packed {
        mark_t [NUM_LINES-1:0][NUM_CHUNKS-1:0] marks;
    } store_t;

    store_t st_d, st_q;
    logic [NUM_LINES-1:0] line_ce_all, line_ue_all;

    assign line_done = fwd_en && (fwd_chunk == LAST_CHUNK);

    always_comb begin
        st_d = st_q;
        for (int l = 0; l < NUM_LINES; l++) begin
            for (int c = 0; c < NUM_CHUNKS; c++) begin
                // whole slot is released once its last chunk leaves
                if (line_done && fwd_line == LINE_W'(l)) begin
                    st_d.marks[l][c] = '0;
                end
                // a new fill of the same chunk lands after the release
                if (wr_en && wr_line == LINE_W'(l) && wr_chunk == CHUNK_W'(c)) begin
                    st_d.marks[l][c].ce = st_d.marks[l][c].ce | wr_mark.ce;
                    st_d.marks[l][c].ue = st_d.marks[l][c].ue | wr_mark.ue;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // per-slot OR of every chunk mark
    for (genvar gl = 0; gl < NUM_LINES; gl++) begin : g_line_or
        logic [NUM_CHUNKS-1:0] ce_vec, ue_vec;
        for (genvar gc = 0; gc < NUM_CHUNKS; gc++) begin : g_chunk
            assign ce_vec[gc] = st_q.marks[gl][gc].ce;
            assign ue_vec[gc] = st_q.marks[gl][gc].ue;
        end
        assign line_ce_all[gl] = |ce_vec;
        assign line_ue_all[gl] = |ue_vec;
    end

    assign chunk_mark   = st_q.marks[fwd_line][fwd_chunk];
    assign line_mark.ce = line_ce_all[fwd_line];
    assign line_mark.ue = line_ue_all[fwd_line];

endmodule

// File: rtl/ebl_err_log.sv
module ebl_err_log
    import ebl_pkg::*;
#(
    parameter int LINE_W  = 2,
    parameter int CHUNK_W = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               fwd_en,
    input  logic [LINE_W-1:0]  fwd_line,
    input  logic [CHUNK_W-1:0] fwd_chunk,
    input  mark_t              chunk_mark,
    input  logic               clr_first,
    input  logic               clr_next,
    output logic               first_valid,
    output logic               first_ue,
    output logic [LINE_W-1:0]  first_line,
    output logic [CHUNK_W-1:0] first_chunk,
    output logic               next_ce,
    output logic               next_ue
);

    typedef struct packed {
        logic               valid;
        logic               ue;
        logic [LINE_W-1:0]  line;
        logic [CHUNK_W-1:0] chunk;
    } first_t;

    typedef struct packed {
        first_t first;
        logic   nce;
        logic   nue;
    } log_t;

    log_t log_d, log_q;
    logic chunk_err;

    assign chunk_err = fwd_en && mark_any(chunk_mark);

    always_comb begin
        log_d = log_q;
        // clears act before the error of the same cycle is logged
        if (clr_first) begin
            log_d.first = '0;
        end
        if (clr_next) begin
            log_d.nce = 1'b0;
            log_d.nue = 1'b0;
        end
        if (chunk_err) begin
            if (!log_d.first.valid) begin
                log_d.first.valid = 1'b1;
                log_d.first.ue    = chunk_mark.ue;
                log_d.first.line  = fwd_line;
                log_d.first.chunk = fwd_chunk;
            end else if (chunk_mark.ue) begin
                log_d.nue = 1'b1;
            end else begin
                log_d.nce = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            log_q <= '0;
        end else begin
            log_q <= log_d;
        end
    end

    assign first_valid = log_q.first.valid;
    assign first_ue    = log_q.first.ue;
    assign first_line  = log_q.first.line;
    assign first_chunk = log_q.first.chunk;
    assign next_ce     = log_q.nce;
    assign next_ue     = log_q.nue;

    // R5
    first_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        log_q.first.valid && !clr_first |=> log_q.first.valid);

    // R5
    first_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        log_q.first.valid && !clr_first |=> $stable(log_q.first));

    // R6
    next_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (log_q.nce || log_q.nue) && !clr_next |=> (log_q.nce || log_q.nue));

    // R6
    next_needs_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(log_q.nce || log_q.nue) |-> $past(log_q.first.valid));

endmodule

// File: rtl/ebl_up_report.sv
module ebl_up_report
    import ebl_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  line_done,
    input  mark_t line_mark,
    output logic  up_valid,
    output logic  up_ce,
    output logic  up_ue
);

    typedef struct packed {
        logic  valid;
        mark_t mark;
    } rpt_t;

    rpt_t rpt_d, rpt_q;

    always_comb begin
        rpt_d       = '0;
        rpt_d.valid = line_done;
        if (line_done) begin
            rpt_d.mark = line_mark;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rpt_q <= '0;
        end else begin
            rpt_q <= rpt_d;
        end
    end

    assign up_valid = rpt_q.valid;
    assign up_ce    = rpt_q.mark.ce;
    assign up_ue    = rpt_q.mark.ue;

endmodule

// File: rtl/chunk_err_logger.sv
module chunk_err_logger
    import ebl_pkg::*;
#(
    parameter int NUM_LINES  = 4,
    parameter int NUM_CHUNKS = 4,
    localparam int LINE_W    = (NUM_LINES  > 1) ? $clog2(NUM_LINES)  : 1,
    localparam int CHUNK_W   = (NUM_CHUNKS > 1) ? $clog2(NUM_CHUNKS) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [LINE_W-1:0]  wr_line,
    input  logic [CHUNK_W-1:0] wr_chunk,
    input  logic               wr_ce,
    input  logic               wr_ue,
    input  logic               fwd_en,
    input  logic [LINE_W-1:0]  fwd_line,
    input  logic [CHUNK_W-1:0] fwd_chunk,
    input  logic               clr_first,
    input  logic               clr_next,
    output logic               up_valid,
    output logic               up_ce,
    output logic               up_ue,
    output logic               first_valid,
    output logic               first_ue,
    output logic [LINE_W-1:0]  first_line,
    output logic [CHUNK_W-1:0] first_chunk,
    output logic               next_ce,
    output logic               next_ue
);

    localparam logic [CHUNK_W-1:0] LAST_CHUNK = CHUNK_W'(NUM_CHUNKS - 1);

    mark_t wr_mark, chunk_mark, line_mark;
    logic  line_done;

    assign wr_mark.ce = wr_ce;
    assign wr_mark.ue = wr_ue;

    ebl_mark_store #(
        .NUM_LINES (NUM_LINES),
        .NUM_CHUNKS(NUM_CHUNKS),
        .LINE_W    (LINE_W),
        .CHUNK_W   (CHUNK_W)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_line   (wr_line),
        .wr_chunk  (wr_chunk),
        .wr_mark   (wr_mark),
        .fwd_en    (fwd_en),
        .fwd_line  (fwd_line),
        .fwd_chunk (fwd_chunk),
        .chunk_mark(chunk_mark),
        .line_mark (line_mark),
        .line_done (line_done)
    );

    ebl_err_log #(
        .LINE_W (LINE_W),
        .CHUNK_W(CHUNK_W)
    ) u_log (
        .clk        (clk),
        .rst_n      (rst_n),
        .fwd_en     (fwd_en),
        .fwd_line   (fwd_line),
        .fwd_chunk  (fwd_chunk),
        .chunk_mark (chunk_mark),
        .clr_first  (clr_first),
        .clr_next   (clr_next),
        .first_valid(first_valid),
        .first_ue   (first_ue),
        .first_line (first_line),
        .first_chunk(first_chunk),
        .next_ce    (next_ce),
        .next_ue    (next_ue)
    );

    ebl_up_report u_up (
        .clk      (clk),
        .rst_n    (rst_n),
        .line_done(line_done),
        .line_mark(line_mark),
        .up_valid (up_valid),
        .up_ce    (up_ce),
        .up_ue    (up_ue)
    );

    // R7
    up_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        up_valid |-> $past(fwd_en && fwd_chunk == LAST_CHUNK));

    // R7
    up_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fwd_en && fwd_chunk != LAST_CHUNK |=> !up_valid);

endmodule

// File: tb/chunk_err_logger_test.sv
module chunk_err_logger_test;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       wr_en, wr_ce, wr_ue, fwd_en, clr_first, clr_next;
    logic [1:0] wr_line, wr_chunk, fwd_line, fwd_chunk;
    logic       up_valid, up_ce, up_ue;
    logic       first_valid, first_ue, next_ce, next_ue;
    logic [1:0] first_line, first_chunk;

    int n_checks = 0;
    int n_fail   = 0;
    logic [1:0] exp_q[$];          // {ue, ce} per expected report
    logic mce[4][4];
    logic mue[4][4];

    always #5 clk = ~clk;

    chunk_err_logger uut (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_line(wr_line), .wr_chunk(wr_chunk),
        .wr_ce(wr_ce), .wr_ue(wr_ue),
        .fwd_en(fwd_en), .fwd_line(fwd_line), .fwd_chunk(fwd_chunk),
        .clr_first(clr_first), .clr_next(clr_next),
        .up_valid(up_valid), .up_ce(up_ce), .up_ue(up_ue),
        .first_valid(first_valid), .first_ue(first_ue),
        .first_line(first_line), .first_chunk(first_chunk),
        .next_ce(next_ce), .next_ue(next_ue)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic check_log(input string req, input int v, input int ue,
                             input int ln, input int ch, input int nce, input int nue);
        check({req, " first_valid"}, int'(first_valid), v);
        if (v != 0) begin
            check({req, " first_ue"}, int'(first_ue), ue);
            check({req, " first_line"}, int'(first_line), ln);
            check({req, " first_chunk"}, int'(first_chunk), ch);
        end
        check({req, " next_ce"}, int'(next_ce), nce);
        check({req, " next_ue"}, int'(next_ue), nue);
    endtask

    // One cycle of stimulus; returns at the following falling edge
    task automatic step(input logic we, input int wl, input int wc, input logic ce,
                        input logic ue, input logic fe, input int fl, input int fc,
                        input logic cf, input logic cn);
        @(negedge clk);
        wr_en = we; wr_line = 2'(wl); wr_chunk = 2'(wc); wr_ce = ce; wr_ue = ue;
        fwd_en = fe; fwd_line = 2'(fl); fwd_chunk = 2'(fc);
        clr_first = cf; clr_next = cn;
        if (fe && fc == 3) begin
            logic oce, oue;
            oce = 1'b0; oue = 1'b0;
            for (int c = 0; c < 4; c++) begin
                oce |= mce[fl][c]; oue |= mue[fl][c];
                mce[fl][c] = 1'b0; mue[fl][c] = 1'b0;
            end
            exp_q.push_back({oue, oce});
        end
        if (we) begin
            mce[wl][wc] |= ce; mue[wl][wc] |= ue;
        end
        @(negedge clk);
        wr_en = 0; fwd_en = 0; clr_first = 0; clr_next = 0;
    endtask

    task automatic wr(input int l, input int c, input logic ce, input logic ue);
        step(1, l, c, ce, ue, 0, 0, 0, 0, 0);
    endtask

    task automatic fwd(input int l, input int c, input logic cf, input logic cn);
        step(0, 0, 0, 0, 0, 1, l, c, cf, cn);
    endtask

    task automatic fwd_line_all(input int l);
        for (int c = 0; c < 4; c++) fwd(l, c, 0, 0);
    endtask

    // Scoreboard monitor (R7, R8)
    always @(negedge clk) begin
        if (rst_n && up_valid) begin
            if (exp_q.size() == 0) begin
                check("R7 unexpected report", 1, 0);
            end else begin
                logic [1:0] e;
                e = exp_q.pop_front();
                check("R7 up_ce", int'(up_ce), int'(e[0]));
                check("R7 up_ue", int'(up_ue), int'(e[1]));
            end
        end
    end

    initial begin
        #2_000_000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        for (int l = 0; l < 4; l++)
            for (int c = 0; c < 4; c++) begin mce[l][c] = 0; mue[l][c] = 0; end
        rst_n = 0; wr_en = 0; wr_ce = 0; wr_ue = 0; fwd_en = 0;
        clr_first = 0; clr_next = 0;
        wr_line = 0; wr_chunk = 0; fwd_line = 0; fwd_chunk = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        check_log("R1", 0, 0, 0, 0, 0, 0);
        check("R1 up_valid", int'(up_valid), 0);

        // R2 marks do not log at write time
        wr(0, 1, 1, 0);
        check("R2 first_valid after write", int'(first_valid), 0);
        wr(0, 1, 0, 1);

        // R3, R5 both words of one chunk bad: single uncorrectable error
        fwd_line_all(0);
        check_log("R3", 1, 1, 0, 1, 0, 0);

        // R9 slot cleared after last chunk
        fwd_line_all(0);
        check_log("R9", 1, 1, 0, 1, 0, 0);

        // R10 clear first
        fwd(0, 0, 1, 0);
        check("R10 clr_first", int'(first_valid), 0);
        exp_q.push_back(2'b00);  // finish line 0 cleanly
        fwd(0, 1, 0, 0); fwd(0, 2, 0, 0);
        void'(exp_q.pop_back());
        fwd(0, 3, 0, 0);

        // R4, R6 two bad chunks in one line
        wr(2, 0, 1, 0);
        wr(2, 3, 1, 0);
        fwd_line_all(2);
        check_log("R4", 1, 0, 2, 0, 1, 0);

        // R11, R8 independent slots and clean report
        wr(1, 2, 0, 1);
        fwd_line_all(3);
        check_log("R11", 1, 0, 2, 0, 1, 0);
        fwd_line_all(1);
        check_log("R5 R6", 1, 0, 2, 0, 1, 1);

        // R10 clear next
        fwd(3, 0, 0, 1);
        check_log("R10 clr_next", 1, 0, 2, 0, 0, 0);
        fwd(3, 1, 0, 0); fwd(3, 2, 0, 0); fwd(3, 3, 0, 0);

        // R10 clr_first in the same cycle as a new error
        wr(0, 0, 0, 1);
        fwd(0, 0, 1, 0);
        check_log("R10 same-cycle first", 1, 1, 0, 0, 0, 0);
        fwd(0, 1, 0, 0); fwd(0, 2, 0, 0); fwd(0, 3, 0, 0);

        // R10 clr_next in the same cycle as a new error
        wr(3, 2, 1, 0);
        fwd(3, 0, 0, 0); fwd(3, 1, 0, 0);
        fwd(3, 2, 0, 1);
        check_log("R10 same-cycle next", 1, 1, 0, 0, 1, 0);
        fwd(3, 3, 0, 0);

        repeat (3) @(negedge clk);
        check("R7 pending reports", exp_q.size(), 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule